// File: doc/BRIEF.md
# Programmable-Step Wrapping Counter

This block is a synchronous N-bit counter. On each enabled rising clock edge it adds or subtracts a step taken from an input port. The result always wraps modulo 2^N. A direction input picks which way it counts. A parameter holds the start value, which is the value the counter shows when it starts and the value it returns to after every restart. While the enable input is low, the visible count is forced to zero.

Control is a two-state machine: `ST_PARKED` and `ST_RUN`. It has five named transitions:

- **RESET**: any state goes to `ST_PARKED` when `rst` is high. Reset takes priority over everything else.
- **IDLE**: `ST_PARKED` stays in `ST_PARKED` while `en` is low.
- **ARM**: `ST_PARKED` goes to `ST_RUN` when `en` is high. The internal count is already at the start value, so the output shows it.
- **ADVANCE**: `ST_RUN` stays in `ST_RUN` while `en` is high. The count moves by one step.
- **DROP**: `ST_RUN` goes to `ST_PARKED` when `en` is low. The internal count is reloaded with the start value.

The output equals the internal count in `ST_RUN` and is zero in `ST_PARKED`.

Top module: `stepctr_top`

## Requirements
- R1: In `ST_RUN` with `en`=1 and `dir`=0, the count one edge later is (count + step) mod 2^WIDTH. Example, 4 bits: 14 + 3 gives 1.
- R2: In `ST_RUN` with `en`=1 and `dir`=1, the count one edge later is (count − step) mod 2^WIDTH, using N-bit two's-complement wrap. Example, 4 bits: 1 − 3 gives 14.
- R3: `dir` is encoded as 0 for counting up and 1 for counting down. It is sampled at every edge, so a change takes effect on the very next edge.
- R4: `WIDTH` (default 4), `STEP_W` (default 6) and `START` (default 5) are parameters. The design is exercised with a step of 3.
- R5: An edge with `en`=0 makes `count` read 0 after that edge. It stays 0 while `en` stays low, whatever `dir` and `step` do.
- R6: `rst` is synchronous and active high. After a reset edge `count` reads 0 and the internal count holds `START`. Reset wins over `en`=1.
- R7: The first edge with `en`=1 after a reset or after a low `en` (the ARM transition) makes `count` read `START`. Counting then continues from `START`, not from any earlier value.
- R8: A step of 0 holds the count unchanged in either direction.
- R9: Only the low `WIDTH` bits of `step` are used. A step of 2^WIDTH or more is therefore reduced modulo 2^WIDTH. Example, 4 bits: 19 behaves as 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Counting enable; low forces the output to zero |
| dir | input | 1 | 0 = count up, 1 = count down |
| step | input | STEP_W | Step size, reduced modulo 2^WIDTH |
| count | output | WIDTH | Current count, or zero while parked |

## Verification
Reset and enable can arrive in the same edge. So can an enable drop and a change of direction or step. The bench drives `rst` together with `en`=1 and expects a parked, zero output followed by the start value. It also lowers `en` in the same cycle that it flips `dir` and loads large steps, and expects zero, then the start value on the next enable. A behavioural model, plus a random phase that mixes resets, drops and direction changes, judges each cycle.

// File: rtl/stepctr_pkg.sv
package stepctr_pkg;
    typedef enum logic {
        ST_PARKED = 1'b0,
        ST_RUN    = 1'b1
    } run_state_e;

    typedef enum logic {
        ACT_LOAD = 1'b0,
        ACT_STEP = 1'b1
    } cnt_act_e;
endpackage

// File: rtl/stepctr_step.sv
module stepctr_step #(
    parameter int WIDTH  = 4,
    parameter int STEP_W = 6
) (
    input  logic [WIDTH-1:0]  cur_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              down_i,
    output logic [WIDTH-1:0]  nxt_o
);
    logic [WIDTH-1:0] stp_m;

    // Keep only the low WIDTH bits (modulo 2^WIDTH) or zero-extend a narrow step.
    generate
        if (STEP_W >= WIDTH) begin : g_trunc
            assign stp_m = step_i[WIDTH-1:0];
        end else begin : g_ext
            assign stp_m = {{(WIDTH-STEP_W){1'b0}}, step_i};
        end
    endgenerate

    // WIDTH-bit arithmetic wraps naturally in two's complement.
    always_comb begin
        if (down_i) nxt_o = cur_i - stp_m;
        else        nxt_o = cur_i + stp_m;
    end
endmodule

// File: rtl/stepctr_seq.sv
module stepctr_seq
    import stepctr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    output run_state_e state_q,
    output cnt_act_e   act_o
);
    run_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_PARKED;   // RESET
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        act_o   = ACT_LOAD;
        unique case (state_q)
            ST_PARKED: begin
                if (en) state_d = ST_RUN;     // ARM
                else    state_d = ST_PARKED;  // IDLE
                act_o = ACT_LOAD;
            end
            ST_RUN: begin
                if (en) begin
                    state_d = ST_RUN;         // ADVANCE
                    act_o   = ACT_STEP;
                end else begin
                    state_d = ST_PARKED;      // DROP
                    act_o   = ACT_LOAD;
                end
            end
            default: begin
                state_d = ST_PARKED;
                act_o   = ACT_LOAD;
            end
        endcase
    end
endmodule

// File: rtl/stepctr_top.sv
module stepctr_top
    import stepctr_pkg::*;
#(
    parameter int          WIDTH  = 4,
    parameter int          STEP_W = 6,
    parameter int unsigned START  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              dir,
    input  logic [STEP_W-1:0] step,
    output logic [WIDTH-1:0]  count
);
    localparam logic [WIDTH-1:0] START_V = WIDTH'(START);

    run_state_e       state_q;
    cnt_act_e         act;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_nxt;

    stepctr_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .state_q (state_q),
        .act_o   (act)
    );

    stepctr_step #(.WIDTH(WIDTH), .STEP_W(STEP_W)) u_step (
        .cur_i  (cnt_q),
        .step_i (step),
        .down_i (dir),
        .nxt_o  (cnt_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= START_V;
        else if (act == ACT_STEP) cnt_q <= cnt_nxt;
        else                     cnt_q <= START_V;
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:    count = cnt_q;
            ST_PARKED: count = '0;
            default:   count = '0;
        endcase
    end
endmodule

// File: rtl/stepctr_chk.sv
module stepctr_chk #(
    parameter int          WIDTH  = 4,
    parameter int          STEP_W = 6,
    parameter int unsigned START  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              dir,
    input logic [STEP_W-1:0] step,
    input logic [WIDTH-1:0]  count,
    input logic              run_i
);
    logic [WIDTH-1:0] stp_m;
    assign stp_m = WIDTH'(step);

    // R1 R9
    up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && en && !dir) |=> count == WIDTH'($past(count) + $past(stp_m)));

    // R2 R3
    down_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && en && dir) |=> count == WIDTH'($past(count) - $past(stp_m)));

    // R5
    parked_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> count == '0);

    // R6
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (count == '0 && !run_i));

    // R7
    arm_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_i && en) |=> count == WIDTH'(START));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && en && stp_m == '0) |=> $stable(count));
endmodule

bind stepctr_top stepctr_chk #(.WIDTH(WIDTH), .STEP_W(STEP_W), .START(START)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .dir   (dir),
    .step  (step),
    .count (count),
    .run_i (state_q == stepctr_pkg::ST_RUN)
);

// File: tb/stepctr_top_tb.sv
`timescale 1ns/1ps
module stepctr_top_tb;
    localparam int W  = 4;
    localparam int SW = 6;
    localparam int ST = 5;
    localparam int M  = 1 << W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic          dir = 1'b0;
    logic [SW-1:0] step = '0;
    logic [W-1:0]  count;

    int n_cmp = 0;
    int n_bad = 0;
    int m_run = 0;
    int m_cnt = ST;
    bit done  = 0;

    always #4 clk = ~clk;

    stepctr_top #(.WIDTH(W), .STEP_W(SW), .START(ST)) u_dut (
        .clk(clk), .rst(rst), .en(en), .dir(dir), .step(step), .count(count)
    );

    function automatic int model_out();
        return (m_run != 0) ? m_cnt : 0;
    endfunction

    task automatic compare(input string tag, input int exp);
        n_cmp++;
        if (int'(count) != exp) begin
            n_bad++;
            $display("FAIL %s: count=%0d expected=%0d at %0t", tag, count, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, model at posedge, compare at next negedge.
    task automatic cyc(input bit r, input bit e, input bit d, input int s, input string tag);
        int sm;
        rst = r; en = e; dir = d; step = SW'(s);
        @(posedge clk);
        sm = s % M;
        if (r) begin
            m_run = 0; m_cnt = ST;
        end else if (!e) begin
            m_run = 0; m_cnt = ST;
        end else if (m_run == 0) begin
            m_run = 1;
        end else if (d) begin
            m_cnt = (m_cnt - sm + M) % M;
        end else begin
            m_cnt = (m_cnt + sm) % M;
        end
        @(negedge clk);
        compare(tag, model_out());
    endtask

    initial begin
        @(negedge clk);
        // R6: reset with enable high must park at zero
        cyc(1, 1, 0, 3, "R6");
        cyc(1, 1, 0, 3, "R6");
        compare("R6 reset state", 0);
        // R7: arm shows START
        cyc(0, 1, 0, 3, "R7");
        compare("R7 arm", ST);
        // R1 R4: step 3 upward, 5->8->11->14->1
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, 3, "R1");
        compare("R1 wrap up", 1);
        // R2: 1 - 3 -> 14
        cyc(0, 1, 1, 3, "R2");
        compare("R2 wrap down", 14);
        // R3: alternate direction each edge
        for (int i = 0; i < 6; i++) cyc(0, 1, i[0], 5, "R3");
        // R8: zero step holds in both directions
        for (int i = 0; i < 4; i++) cyc(0, 1, i[0], 0, "R8");
        // R9: oversized steps reduced modulo 2^W
        cyc(0, 1, 0, 19, "R9");
        cyc(0, 1, 1, 35, "R9");
        cyc(0, 1, 0, 48, "R9");
        // R5: enable drop together with dir/step changes
        cyc(0, 0, 1, 63, "R5");
        cyc(0, 0, 0, 7, "R5");
        cyc(0, 0, 1, 2, "R5");
        compare("R5 parked", 0);
        // R7: re-enable resumes from START
        cyc(0, 1, 0, 2, "R7");
        compare("R7 resume", ST);
        cyc(0, 1, 0, 2, "R7");
        compare("R7 first step", ST + 2);
        // R6: reset mid-run wins over enable
        cyc(1, 1, 1, 4, "R6");
        compare("R6 mid-run", 0);
        cyc(0, 1, 1, 4, "R7");
        cyc(0, 1, 1, 4, "R2");
        compare("R2 after reset", ST - 4);
        // R10-style mixed random phase covering R1 R2 R3 R5 R6 R7 R9
        for (int i = 0; i < 400; i++) begin
            int rr = $urandom_range(0, 99);
            cyc(rr < 3, rr >= 10, $urandom_range(0, 1) == 1,
                int'($urandom_range(0, (1 << SW) - 1)), "R3 mixed");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule